// File: doc/BRIEF.md
# SSI Position Slave Transmitter

This block is the slave end of a synchronous serial link. It sends a position word to a master, and the master drives the serial clock. A fast system clock oversamples the incoming serial clock through a synchronizer and finds its edges. A falling edge seen while the block is ready starts a package. That edge copies the word held in a holding register into a shift register. Each following rising edge puts the next bit on the data line, most significant bit first.

A word of n bits takes n+1 clock pulses. The extra rising edge at the end drives the line low. After the last falling edge a monoflop timer runs for a set number of system clock cycles. The line stays low until the timer expires, and then the block is ready for the next package. Falling edges that arrive before expiry restart the timer and are not taken as a new package.

The holding register takes the position input whenever its valid strobe is high and the block is ready. If no new word has arrived since the last package, the same word is sent again.

Top module: `ssi_pos_tx`

## Requirements
- R1: A falling serial clock edge seen while ready copies the holding register into the shift register. A word presented during the package does not change the bits sent.
- R2: Between the capture edge and the first rising edge the data line stays high. The first rising edge after capture drives the most significant bit.
- R3: Each rising edge in the package drives the next lower bit. The least significant bit is driven by the n-th rising edge, so the bit order is MSB to LSB.
- R4: A word of WORD_W bits uses WORD_W+1 clock pulses. The (WORD_W+1)-th rising edge and any later rising edge drive the data line low.
- R5: The monoflop timer restarts on every detected falling edge. The block leaves the package state only when MONO_CYC system cycles pass with no falling edge. Until then the data line is low after the final bit.
- R6: A falling edge during the monoflop time does not start a package. It restarts the timer, and the line stays low.
- R7: While ready, the data line is high. The block leaves the ready state only on a detected falling edge.
- R8: The holding register loads pos_i on a cycle where pos_vld_i is high and the block is ready. Strobes during a package are ignored. Without a new strobe, the next package resends the same word.
- R9: After synchronous reset the data line is high, the block is ready and the holding register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ssi_clk_i | input | 1 | Serial clock from the master, idles high, asynchronous |
| pos_i | input | WORD_W | Position word |
| pos_vld_i | input | 1 | Valid strobe for pos_i |
| ssi_data_o | output | 1 | Registered serial data line |

## Verification
The bench builds the block with WORD_W = 12 and MONO_CYC = 32. The serial clock period is 16 system cycles, so the monoflop time is two serial periods. A 12-bit word keeps each package short, so all-ones, single-bit and alternating patterns can each be sent whole. With a 32-cycle timeout, an early falling edge can land inside the monoflop window. The bench can then show that the timer restarts: the line is still low at a point where the first timeout would already have expired.

// File: rtl/ssi_pos_pkg.sv
package ssi_pos_pkg;
  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } ssi_state_e;
endpackage

// File: rtl/ssi_clk_sync.sv
module ssi_clk_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ssi_clk_i,
  output logic rise_o,
  output logic fall_o
);
  // stages 0..SYNC_STAGES-1 synchronize, the last one holds the previous level
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], ssi_clk_i};
  end

  assign rise_o =  sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign fall_o = ~sync_q[SYNC_STAGES-1] &  sync_q[SYNC_STAGES];
endmodule

// File: rtl/ssi_pos_hold.sv
module ssi_pos_hold #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en_i,
  input  logic              pos_vld_i,
  input  logic [WORD_W-1:0] pos_i,
  output logic [WORD_W-1:0] hold_o
);
  always_ff @(posedge clk) begin
    if (rst)                         hold_o <= '0;
    else if (load_en_i && pos_vld_i) hold_o <= pos_i;
  end
endmodule

// File: rtl/ssi_monoflop.sv
module ssi_monoflop #(
  parameter int MONO_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int CW = $clog2(MONO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MONO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i) cnt_q <= '0;
    else if (cnt_q != LAST)         cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && !restart_i && (cnt_q == LAST);
endmodule

// File: rtl/ssi_tx_core.sv
module ssi_tx_core
  import ssi_pos_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              expire_i,
  input  logic [WORD_W-1:0] hold_i,
  output ssi_state_e        state_o,
  output logic              data_o
);
  localparam int BCW = $clog2(WORD_W + 1);
  localparam logic [BCW-1:0] NBITS = BCW'(WORD_W);

  ssi_state_e        state_q;
  logic [WORD_W-1:0] shreg_q;
  logic [BCW-1:0]    bitcnt_q;
  logic              data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_READY;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      data_q   <= 1'b1;
    end else begin
      case (state_q)
        ST_READY: begin
          data_q <= 1'b1;
          if (fall_i) begin
            shreg_q  <= hold_i;
            bitcnt_q <= '0;
            state_q  <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (expire_i) begin
            state_q <= ST_READY;
            data_q  <= 1'b1;
          end else if (rise_i) begin
            if (bitcnt_q == NBITS) begin
              data_q  <= 1'b0;
              state_q <= ST_TAIL;
            end else begin
              data_q   <= shreg_q[WORD_W-1];
              shreg_q  <= shreg_q << 1;
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (expire_i) begin
            state_q <= ST_READY;
            data_q  <= 1'b1;
          end else begin
            data_q <= 1'b0;
          end
        end
        default: begin
          state_q <= ST_READY;
          data_q  <= 1'b1;
        end
      endcase
    end
  end

  assign state_o = state_q;
  assign data_o  = data_q;
endmodule

// File: rtl/ssi_pos_tx.sv
module ssi_pos_tx
  import ssi_pos_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int MONO_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ssi_clk_i,
  input  logic [WORD_W-1:0] pos_i,
  input  logic              pos_vld_i,
  output logic              ssi_data_o
);
  logic              rise, fall, expire;
  logic [WORD_W-1:0] hold;
  ssi_state_e        state;

  ssi_clk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ssi_clk_i(ssi_clk_i),
    .rise_o(rise), .fall_o(fall)
  );

  ssi_pos_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst(rst), .load_en_i(state == ST_READY),
    .pos_vld_i(pos_vld_i), .pos_i(pos_i), .hold_o(hold)
  );

  ssi_monoflop #(.MONO_CYC(MONO_CYC)) u_mono (
    .clk(clk), .rst(rst), .run_i(state != ST_READY),
    .restart_i(fall), .expire_o(expire)
  );

  ssi_tx_core #(.WORD_W(WORD_W)) u_core (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall),
    .expire_i(expire), .hold_i(hold), .state_o(state), .data_o(ssi_data_o)
  );
endmodule

// File: rtl/ssi_pos_tx_chk.sv
module ssi_pos_tx_chk
  import ssi_pos_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              ssi_data_o,
  input logic              fall,
  input logic              expire,
  input logic [WORD_W-1:0] hold,
  input ssi_state_e        state
);
  a_r5_tail_low: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAIL) |-> (ssi_data_o == 1'b0));

  a_r7_ready_high: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READY) |-> (ssi_data_o == 1'b1));

  a_r7_leave_on_fall: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READY && !fall) |=> (state == ST_READY));

  a_r5_exit_on_expire: assert property (@(posedge clk) disable iff (rst)
    (state != ST_READY && !expire) |=> (state != ST_READY));

  a_r8_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (state != ST_READY) |=> $stable(hold));
endmodule

bind ssi_pos_tx ssi_pos_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .ssi_data_o(ssi_data_o), .fall(fall),
  .expire(expire), .hold(hold), .state(state)
);

// File: tb/ssi_pos_tx_test.sv
`timescale 1ns/1ps
module ssi_pos_tx_test;
  localparam int W    = 12;
  localparam int MONO = 32;
  localparam int HALF = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ssi_clk = 1'b1;
  logic [W-1:0] pos = '0;
  logic         vld = 1'b0;
  logic         dout;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ssi_pos_tx #(.WORD_W(W), .MONO_CYC(MONO)) uut (
    .clk(clk), .rst(rst), .ssi_clk_i(ssi_clk),
    .pos_i(pos), .pos_vld_i(vld), .ssi_data_o(dout)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_word(input logic [W-1:0] w);
    @(negedge clk); pos = w; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
  endtask

  // One package. Returns HALF cycles after the final rising edge, with the clock high.
  task automatic run_package(input logic [W-1:0] exp, input logic inject,
                             input logic [W-1:0] other);
    @(negedge clk); ssi_clk = 1'b0;
    wait_n(HALF);
    chk(dout, 1'b1, "R2 line high before first rise");
    if (inject) begin pos = other; vld = 1'b1; end
    for (int i = W - 1; i >= 0; i--) begin
      ssi_clk = 1'b1; wait_n(HALF);
      chk(dout, exp[i], (i == W - 1) ? "R2 MSB first" : "R3 bit order");
      ssi_clk = 1'b0; wait_n(HALF);
    end
    ssi_clk = 1'b1;
    if (inject) vld = 1'b0;
    wait_n(HALF);
    chk(dout, 1'b0, "R4 extra pulse drives low");
  endtask

  // Called HALF cycles after the final rise, which is 2*HALF after the last fall.
  task automatic finish_tail;
    wait_n(10);
    chk(dout, 1'b0, "R5 low during monoflop");
    wait_n(20);
    chk(dout, 1'b1, "R5 high after monoflop");
  endtask

  task automatic t_reset;
    wait_n(2);
    chk(dout, 1'b1, "R9 reset line high");
    run_package('0, 1'b0, '0);   // R9 holding register resets to zero
    finish_tail();
  endtask

  task automatic t_patterns;
    logic [W-1:0] pats [4] = '{12'hA5C, 12'hFFF, 12'h001, 12'h800};
    foreach (pats[k]) begin
      load_word(pats[k]);
      run_package(pats[k], 1'b0, '0);
      finish_tail();
    end
  endtask

  task automatic t_freeze_and_repeat;
    load_word(12'h3C6);
    run_package(12'h3C6, 1'b1, 12'h9A1);  // R1 word frozen during package
    finish_tail();
    wait_n(4);
    chk(dout, 1'b1, "R7 idle high");
    run_package(12'h3C6, 1'b0, '0);       // R8 strobe inside package ignored
    finish_tail();
    run_package(12'h3C6, 1'b0, '0);       // R8 same word resent
    finish_tail();
  endtask

  task automatic t_early_clock;
    load_word(12'h5A3);
    run_package(12'h5A3, 1'b0, '0);
    ssi_clk = 1'b0;                       // fall inside the monoflop window
    wait_n(HALF);
    chk(dout, 1'b0, "R6 early fall keeps line low");
    ssi_clk = 1'b1; wait_n(HALF);
    chk(dout, 1'b0, "R6 early rise keeps line low");
    wait_n(12);
    chk(dout, 1'b0, "R6 timer restarted by early fall");
    wait_n(20);
    chk(dout, 1'b1, "R5 expiry after early fall");
    run_package(12'h5A3, 1'b0, '0);       // R6 next package aligned
    finish_tail();
  endtask

  initial begin
    wait_n(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_patterns();
    t_freeze_and_repeat();
    t_early_clock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule